// File: doc/BRIEF.md
# Rewindable Strobe-Driven FIFO with Half-Full Flag

This block is a first-in first-out buffer of 9-bit words, 512 deep by default (1024 by parameter), controlled by active-low strobes in the manner of an asynchronous FIFO part. A single system clock samples the write, read and retransmit strobes. Each strobe passes through a two-stage synchronizer and a one-cycle delay register, and every operation is triggered by a detected edge of a synchronized strobe. Three active-low flags report the fill level: empty, more than half full, and full. The read-data bus has an enable output that stands in for a three-state driver.

Writes are armed on the falling edge of the write strobe and committed on its rising edge, which is when the input word is captured. Reads take place on the falling edge of the read strobe. The word is then presented with its enable until the strobe rises again. A low pulse on the retransmit input rewinds the read pointer to physical location zero, so that a receiver can ask for a block of data again. Replay then runs up to the current write position, and words written afterwards follow in order. A master reset empties the buffer at any time.

Top module: `rewind_fifo`

## Requirements
- R1: Words leave in the order they were written. The depth is set by `DEPTH` (a power of two: 512 by default, 1024 supported) and the word width by `WIDTH` (9).
- R2: While `mr_n` is low and after it rises, `empty_n` is 0, `half_n` is 1, `full_n` is 1 and `dout_oe` is 0.
- R3: A write committed while the buffer is full is dropped and the write pointer holds. A read strobe while the buffer is empty is dropped, the read pointer holds and `dout_oe` stays 0.
- R4: `din` is stored when the rising edge of `wr_n` is detected, provided the falling edge of the same strobe found the buffer not full.
- R5: `half_n` is 0 exactly when occupancy is greater than DEPTH/2. It falls on the write that brings the count to DEPTH/2+1 and rises on the read that brings it back to DEPTH/2.
- R6: `full_n` is 0 exactly when occupancy equals DEPTH. `empty_n` is 0 exactly when occupancy is 0. The two are never low together.
- R7: A falling edge on `rt_n` moves the read pointer to location 0. The new occupancy is the write address if that is nonzero. If the write address is zero, the new occupancy is DEPTH when the buffer held data and 0 when it did not. All flags follow the new occupancy.
- R8: After a retransmit, reads replay the stored words from location 0 and then deliver words written later. Write and read strobe edges seen while the synchronized `rt_n` is low are discarded.
- R9: `dout_oe` is 1 only between an accepted read edge and the next rising edge of `rd_n`. During that time `dout` holds the word that was read.
- R10: An operation takes effect on the third clock edge after its strobe changes. The flags show the result one cycle after the second edge at the latest, and each strobe edge causes at most one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| mr_n | input | 1 | Master reset, active low, asynchronous assert |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Retransmit strobe, active low |
| din | input | WIDTH | Write data, captured at the detected rising edge of `wr_n` |
| dout | output | WIDTH | Read data |
| dout_oe | output | 1 | Read-data enable (stands in for three-state drive) |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |
| full_n | output | 1 | Full flag, active low |

## Verification
A pointer that is off by one shows up at the flags within three clocks of the strobe that caused it. `half_n` moves one word early or late, `full_n` appears one write early, or a read data word comes from the neighbouring location. A wrong retransmit offset changes both the number of words replayed before `empty_n` falls and their values, so every replayed word is compared. A strobe that leaks through while retransmit is held, or a dropped write that still advances the pointer, changes the count of readable words. A drain that runs to empty exposes this at once.

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             half_n,
  output logic             full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [2:0] wr_q, rd_q, rt_q;
  logic [PW-1:0] wptr, rptr;
  logic [WIDTH-1:0] mem [DEPTH];
  logic armed, rd_live;

  always_ff @(posedge clk or negedge mr_n)
    if (!mr_n) begin
      wr_q <= '1;
      rd_q <= '1;
      rt_q <= '1;
    end else begin
      wr_q <= {wr_q[1:0], wr_n};
      rd_q <= {rd_q[1:0], rd_n};
      rt_q <= {rt_q[1:0], rt_n};
    end

  wire rt_idle = rt_q[1];
  wire wr_fall = wr_q[2] & ~wr_q[1] & rt_idle;
  wire wr_rise = ~wr_q[2] & wr_q[1] & rt_idle;
  wire rd_fall = rd_q[2] & ~rd_q[1] & rt_idle;
  wire rd_rise = ~rd_q[2] & rd_q[1];
  wire rt_fall = rt_q[2] & ~rt_q[1];

  wire [PW-1:0] occ   = wptr - rptr;
  wire          empty = (occ == '0);
  wire          full  = (occ == FULL_CNT);
  wire [AW-1:0] waddr = wptr[AW-1:0];
  wire [PW-1:0] rew_occ = (waddr != '0) ? {1'b0, waddr} : (empty ? '0 : FULL_CNT);

  wire wr_commit = wr_rise & armed;
  wire rd_take   = rd_fall & ~empty;

  always_ff @(posedge clk)
    if (wr_commit) mem[waddr] <= din;

  always_ff @(posedge clk or negedge mr_n)
    if (!mr_n) begin
      wptr    <= '0;
      rptr    <= '0;
      armed   <= 1'b0;
      rd_live <= 1'b0;
      dout    <= '0;
    end else begin
      if (wr_commit) wptr <= wptr + 1'b1;
      if (rt_fall)      rptr <= wptr - rew_occ;
      else if (rd_take) rptr <= rptr + 1'b1;
      if (!rt_idle)             armed <= 1'b0;
      else if (wr_fall && !full) armed <= 1'b1;
      else if (wr_commit)        armed <= 1'b0;
      if (rd_take) begin
        rd_live <= 1'b1;
        dout    <= mem[rptr[AW-1:0]];
      end else if (rd_rise) rd_live <= 1'b0;
    end

  assign dout_oe = rd_live;
  assign empty_n = ~empty;
  assign full_n  = ~full;
  assign half_n  = ~(occ > HALF_CNT);
endmodule

module rewind_fifo_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          mr_n,
  input logic          empty_n,
  input logic          half_n,
  input logic          full_n,
  input logic          dout_oe,
  input logic          wr_commit,
  input logic          rt_fall,
  input logic [PW-1:0] rptr
);
  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!mr_n)
    $rose(mr_n) |-> (!empty_n && half_n && full_n && !dout_oe)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mr_n)
    wr_commit |-> full_n); // R3
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!mr_n)
    (!empty_n && !rt_fall) |=> $stable(rptr)); // R3
  AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!mr_n)
    !full_n |-> !half_n); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!mr_n)
    !(!full_n && !empty_n)); // R6
  AST_OE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!mr_n)
    $rose(dout_oe) |-> $past(empty_n)); // R9
endmodule

bind rewind_fifo rewind_fifo_chk #(.PW(PW)) u_chk (
  .clk(clk), .mr_n(mr_n), .empty_n(empty_n), .half_n(half_n), .full_n(full_n),
  .dout_oe(dout_oe), .wr_commit(wr_commit), .rt_fall(rt_fall), .rptr(rptr)
);

// File: tb/test_rewind_fifo.sv
module test_rewind_fifo;
  localparam int D = 512;
  localparam int W = 9;

  logic clk = 1'b0;
  logic mr_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_oe, empty_n, half_n, full_n;

  rewind_fifo #(.DEPTH(D), .WIDTH(W)) i_rewind_fifo (
    .clk(clk), .mr_n(mr_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] model [D];
  int wp = 0, rp = 0;

  function automatic int occ();
    return (wp - rp + 2 * D) % (2 * D);
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req);
    int o = occ();
    chk(req, {29'd0, empty_n, half_n, full_n},
        {29'd0, (o != 0), !(o > D / 2), (o != D)});
  endtask

  task automatic do_reset();
    @(negedge clk) mr_n = 1'b0;
    repeat (2) @(negedge clk);
    mr_n = 1'b1;
    wp = 0; rp = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(logic [W-1:0] d, bit model_on);
    @(negedge clk) wr_n = 1'b0;
    din = d;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    if (model_on && occ() < D) begin
      model[wp % D] = d;
      wp = (wp + 1) % (2 * D);
    end
  endtask

  task automatic do_read(string req);
    bit valid = (occ() != 0);
    @(negedge clk) rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({req, " oe"}, dout_oe, valid);
    if (valid) begin
      chk({req, " data"}, dout, model[rp % D]);
      rp = (rp + 1) % (2 * D);
    end
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 oe after release", dout_oe, 0);
  endtask

  task automatic do_rewind();
    int wa, n;
    @(negedge clk) rt_n = 1'b0;
    repeat (5) @(negedge clk);
    rt_n = 1'b1;
    repeat (5) @(negedge clk);
    wa = wp % D;
    n = (wa != 0) ? wa : ((occ() != 0) ? D : 0);
    rp = (wp - n + 2 * D) % (2 * D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 flags in reset", {29'd0, empty_n, half_n, full_n}, 3'b011);
    mr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 flags after reset", {29'd0, empty_n, half_n, full_n}, 3'b011);
    chk("R2 oe after reset", dout_oe, 0);

    do_read("R3 read when empty");
    chk_flags("R3 flags after empty read");

    // R10: latency of the write commit
    @(negedge clk) wr_n = 1'b0;
    din = 9'h15A;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 empty before third edge", empty_n, 0);
    @(negedge clk);
    chk("R10 empty after third edge", empty_n, 1);
    model[0] = 9'h15A; wp = 1;
    repeat (3) @(negedge clk);

    // R1 R4 R5 R6: fill the buffer, checking the flags at every count
    for (int i = 1; i < D; i++) begin
      do_write(9'((i * 37 + 5) & 9'h1FF), 1);
      chk_flags("R5/R6 fill flags");
    end
    do_write(9'h0AA, 1);
    chk_flags("R3 write when full");

    // drain: order, flags, half release
    for (int i = 0; i < D; i++) begin
      do_read("R1 R4 drain");
      chk_flags("R5/R6 drain flags");
    end
    do_read("R3 read after drain");

    // R7 R8: partial rewind
    do_reset();
    chk_flags("R2 flags after second reset");
    for (int i = 0; i < 10; i++) do_write(9'(100 + i), 1);
    for (int i = 0; i < 4; i++) do_read("R1 pre-rewind");
    do_rewind();
    chk_flags("R7 flags after rewind");
    for (int i = 0; i < 3; i++) do_write(9'(200 + i), 1);
    for (int i = 0; i < 13; i++) do_read("R8 replay");
    chk("R8 empty after replay", empty_n, 0);

    // R8: strobes during retransmit are discarded
    do_reset();
    for (int i = 0; i < 5; i++) do_write(9'(300 + i), 1);
    @(negedge clk) rt_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b0; din = 9'h1EE;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 read during rewind oe", dout_oe, 0);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    rt_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_flags("R8 flags after held rewind");
    for (int i = 0; i < 6; i++) do_read("R8 discard count");

    // R7: rewind of a full buffer
    do_reset();
    for (int i = 0; i < D; i++) do_write(9'((i * 11) & 9'h1FF), 1);
    for (int i = 0; i < 3; i++) do_read("R7 read before full rewind");
    do_rewind();
    chk_flags("R7 full after rewind");
    chk("R7 full flag", full_n, 0);
    for (int i = 0; i < 4; i++) do_read("R7 replay from zero");

    // R2: reset with data present
    do_reset();
    chk("R2 reset mid-run", {29'd0, empty_n, half_n, full_n, dout_oe}, 4'b0110);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule